// File: doc/BRIEF.md
# Show-Ahead FIFO on Synchronous-Read Memory

This block is a first-in first-out queue whose storage is a two-port memory with one write port and one read port, where the read data appears one clock after the address is presented. Outside the block that latency cannot be seen. The oldest stored word is always present on the data output whenever the queue holds anything, as it would be with a queue built on combinational-read memory. The consumer looks at the output, and a pop only moves the queue on to the next word.

The control logic reads ahead. On every cycle it sends the memory the address of the word that will be at the head on the next cycle: the current read pointer, or that pointer plus one when a pop is being accepted. In one case the memory cannot return correct data in time. That case is a word written in the same cycle in which the queue becomes, or stays, empty after any pop. The control then loads the incoming word into a side register as well, and the output takes its data from that register for the next cycle. After that cycle the memory has the word, and the look-ahead reads supply the output again.

Depth must be a power of two and at least two. A usage count drives the full and empty flags. A synchronous flush clears the queue in one cycle.

Top module: `sync_ram_fifo`

## Requirements
- R1: After reset, `emptyO` is 1, `fullO` is 0 and `usageO` is 0.
- R2: While `usageO` is non-zero, `dataO` equals the oldest stored word with no pop needed, and each accepted pop presents the next word in the cycle after it.
- R3: A word pushed while the queue is empty appears on `dataO` in the next cycle, and a pop in that cycle removes it.
- R4: With one word stored, a push and a pop in the same cycle remove the old word and leave the new word on `dataO` in the next cycle, with `usageO` still 1.
- R5: A push while `fullO` is 1 and no pop is offered is ignored: `usageO` stays at the depth and the stored words and their order do not change.
- R6: A pop while `emptyO` is 1 is ignored: `usageO` stays 0, and a later push behaves as it would into an empty queue.
- R7: While `fullO` is 1, a push and a pop in the same cycle are both accepted: `fullO` stays 1 and the pushed word becomes the newest entry.
- R8: `usageO` equals the number of stored words, `emptyO` is 1 exactly when it is 0, and `fullO` is 1 exactly when it equals the depth.
- R9: `flushI` has priority over push and pop. In the cycle after it, the queue is empty, and a push offered in the same cycle as the flush is discarded.
- R10: Words leave in the order they were accepted across any number of pointer wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| flushI | input | 1 | Synchronous clear of all stored words |
| pushI | input | 1 | Write request for `dataI` |
| dataI | input | WIDTH | Word to write |
| popI | input | 1 | Remove the word shown on `dataO` |
| dataO | output | WIDTH | Oldest stored word, valid while not empty |
| fullO | output | 1 | Queue holds DEPTH words |
| emptyO | output | 1 | Queue holds no words |
| usageO | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
The bench runs every five-cycle sequence of push and pop requests from an empty queue, with a flush between sequences. This covers every order in which a word written into an empty queue can be followed by a pop, a push, both or neither. It separates side-register reads from memory reads, and shows a stale look-ahead read at once. Directed runs fill the queue and then offer pushes without pops, pushes with pops, and pops on an empty queue, to test full-boundary acceptance and the ignore rules. A long pseudo-random run then wraps the pointers many times. A reference queue in the bench predicts every output word, flag and count.

// File: rtl/sync_ram_fifo_pkg.sv
package sync_ram_fifo_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic wrEn;    // write dataI into memory at the write address
    logic capAux;  // also load dataI into the side register
    logic useAux;  // output takes side register this cycle
  } fifoStrobe_t;

endpackage

// File: rtl/sync_ram_fifo_mem.sv
module sync_ram_fifo_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] cells [DEPTH];

  // Independent ports; read data is registered (one-cycle latency)
  always_ff @(posedge clk) begin
    if (wrEn) cells[wrAddr] <= wrData;
    rdData <= cells[rdAddr];
  end

endmodule

// File: rtl/sync_ram_fifo_ctrl.sv
module sync_ram_fifo_ctrl
  import sync_ram_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flushI,
  input  logic          pushI,
  input  logic          popI,
  output fifoStrobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullO,
  output logic          emptyO,
  output logic [CW-1:0] usageO
);

  initial begin
    depth_pow2_chk: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("DEPTH must be a power of two, at least 2");
  end

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          auxSel;
  logic          pushAcc, popAcc, capAux;

  assign emptyO = (count == '0);
  assign fullO  = (count == CW'(DEPTH));
  assign usageO = count;

  assign popAcc  = popI && !emptyO && !flushI;
  assign pushAcc = pushI && !flushI && (!fullO || popAcc);

  // Look-ahead address: the word that will be head next cycle
  assign rdAddr = rdPtr + AW'(popAcc);
  assign wrAddr = wrPtr;

  // Memory cannot return a word written this cycle: keep a copy
  assign capAux = pushAcc && (count == CW'(popAcc));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      auxSel <= 1'b0;
    end else if (flushI) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      auxSel <= 1'b0;
    end else begin
      if (pushAcc) wrPtr <= wrPtr + 1'b1;
      if (popAcc)  rdPtr <= rdPtr + 1'b1;
      count  <= count + CW'(pushAcc) - CW'(popAcc);
      auxSel <= capAux;
    end
  end

  assign strobe.wrEn   = pushAcc;
  assign strobe.capAux = capAux;
  assign strobe.useAux = auxSel;

  // R8
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fullO && emptyO));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    usageO <= CW'(DEPTH));

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullO && pushI && !popI && !flushI |=> fullO && $stable(usageO));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyO && popI && !pushI && !flushI |=> emptyO);

  // R7
  full_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullO && pushI && popI && !flushI |=> fullO);

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushI |=> emptyO && !strobe.useAux);

endmodule

// File: rtl/sync_ram_fifo_dp.sv
module sync_ram_fifo_dp
  import sync_ram_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] dataI,
  output logic [WIDTH-1:0] dataO
);

  logic [WIDTH-1:0] ramQ;
  logic [WIDTH-1:0] auxQ;

  sync_ram_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) mem_i (
    .clk    (clk),
    .wrEn   (strobe.wrEn),
    .wrAddr (wrAddr),
    .wrData (dataI),
    .rdAddr (rdAddr),
    .rdData (ramQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              auxQ <= '0;
    else if (strobe.capAux) auxQ <= dataI;
  end

  assign dataO = strobe.useAux ? auxQ : ramQ;

  // R3
  aux_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capAux && !strobe.wrEn |-> 1'b0);

  // R3
  aux_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capAux |=> auxQ == $past(dataI));

endmodule

// File: rtl/sync_ram_fifo.sv
module sync_ram_fifo
  import sync_ram_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushI,
  input  logic             pushI,
  input  logic [WIDTH-1:0] dataI,
  input  logic             popI,
  output logic [WIDTH-1:0] dataO,
  output logic             fullO,
  output logic             emptyO,
  output logic [CW-1:0]    usageO
);

  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  sync_ram_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .flushI (flushI),
    .pushI  (pushI),
    .popI   (popI),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .fullO  (fullO),
    .emptyO (emptyO),
    .usageO (usageO)
  );

  sync_ram_fifo_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .dataI  (dataI),
    .dataO  (dataO)
  );

endmodule

// File: tb/sync_ram_fifo_tb.sv
module sync_ram_fifo_tb_top;

  localparam int WIDTH = 8;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             flushI = 1'b0;
  logic             pushI = 1'b0;
  logic             popI = 1'b0;
  logic [WIDTH-1:0] dataI = '0;
  logic [WIDTH-1:0] dataO;
  logic             fullO, emptyO;
  logic [CW-1:0]    usageO;

  int checks = 0;
  int errors = 0;
  int model[$];
  logic [WIDTH-1:0] nextVal = 8'h01;
  string tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  sync_ram_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .flushI(flushI), .pushI(pushI), .dataI(dataI),
    .popI(popI), .dataO(dataO), .fullO(fullO), .emptyO(emptyO), .usageO(usageO)
  );

  task automatic checkVal(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare outputs with the model; called away from the rising edge
  task automatic checkOut();
    checkVal("R8", int'(emptyO), int'(model.size() == 0), "emptyO");
    checkVal("R8", int'(fullO), int'(model.size() == DEPTH), "fullO");
    checkVal(tag, int'(usageO), model.size(), "usageO");
    if (model.size() != 0) checkVal(tag, int'(dataO), model[0], "dataO");
  endtask

  // One cycle: check at falling edge, drive, predict, advance
  task automatic step(bit doPush, bit doPop, bit doFlush);
    bit popA, pushA;
    int sz;
    @(negedge clk);
    checkOut();
    sz = model.size();
    pushI  = doPush;
    popI   = doPop;
    flushI = doFlush;
    dataI  = nextVal;
    popA  = doPop && sz > 0 && !doFlush;
    pushA = doPush && !doFlush && (sz < DEPTH || popA);
    if (doFlush)                            tag = "R9";
    else if (doPush && !doPop && sz == DEPTH) tag = "R5";
    else if (doPop && sz == 0)              tag = doPush ? "R3" : "R6";
    else if (doPush && doPop && sz == DEPTH) tag = "R7";
    else if (doPush && doPop && sz == 1)    tag = "R4";
    else if (pushA && sz == 0)              tag = "R3";
    else if (tag != "R10")                  tag = "R2";
    if (doFlush) model.delete();
    else begin
      if (popA)  void'(model.pop_front());
      if (pushA) model.push_back(int'(nextVal));
    end
    nextVal = nextVal + 8'd1;
    @(posedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checkVal("R1", int'(emptyO), 1, "emptyO");
    checkVal("R1", int'(fullO), 0, "fullO");
    checkVal("R1", int'(usageO), 0, "usageO");
    rstN = 1'b1;
    @(posedge clk);

    // Fill, then pushes on full (R5), swap on full (R7)
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 1, 0);
    step(1, 1, 0);
    // Drain, then pops on empty (R6)
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    // Write into empty then pop next cycle (R3)
    for (int i = 0; i < 3; i++) begin step(1, 0, 0); step(0, 1, 0); end
    // Push+pop at one word (R4)
    step(1, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    // Flush with push in same cycle (R9)
    step(1, 0, 0);
    step(1, 0, 1);
    step(0, 0, 0);

    // All five-cycle push/pop sequences from empty
    for (int s = 0; s < 1024; s++) begin
      for (int c = 0; c < 5; c++) step(s[2*c], s[2*c+1], 0);
      step(0, 0, 1);
    end

    // Long random run wrapping the pointers (R10)
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      step(r < 60, (r % 3) != 0, r == 99);
      if (tag != "R9") tag = "R10";
    end
    @(negedge clk);
    checkOut();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule